// File: doc/BRIEF.md
# Aging Priority Bus Arbiter

This block decides, every clock cycle, which of three requesters may drive one shared bus: two DMA queue ports (queue 0 and queue 1) and one CPU port. Each requester presents a request line and a static 3-bit urgency level, where 0 is the most urgent value and 7 the least. The block registers a one-hot grant for the pending requester whose effective level is the most urgent.

DMA requests can be starved by a more urgent CPU or by the other queue. To prevent this, each DMA port keeps an effective level and an aging timer. While its request stays pending without a grant, the timer counts clock cycles, and each time it reaches the programmed interval the effective level moves one step closer to 0. An interval of 0 turns aging off, so only the static levels matter. The CPU is never aged. The system is expected to program queue levels of 0 and a CPU level of 7 as defaults, with aging off. The block's own effective levels clear to 0 at reset.

Top module: `aging_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low) all three grants are low, both aging timers are zero and both DMA effective levels are 0.
- R2: The grant is registered: the grant seen after a rising edge reflects the requests and levels present at that edge. At most one grant is high, and a grant is high only if that requester's request was high at the preceding edge. With no request pending, no grant is issued.
- R3: Among pending requesters, the one with the numerically lowest effective level wins (level 0 most urgent, level 7 least urgent). A DMA port's effective level equals its static level whenever it has no pending ungranted request.
- R4: Equal effective levels are resolved in fixed order: queue 0 first, then queue 1, then the CPU.
- R5: With interval N > 0, a DMA request that is high and not granted at consecutive edges has its effective level lowered by 1 at every Nth such edge. For example, with N = 2, the level drops at the 2nd, 4th and 6th waiting edges.
- R6: With interval 0, no aging happens. The DMA effective levels follow the static level inputs, and a less urgent DMA request never overtakes a more urgent one.
- R7: The CPU is never aged and always competes with its static level input, however long it waits.
- R8: An aged effective level stops at 0 and never wraps to a less urgent value.
- R9: When a DMA port is granted, or drops its request, its effective level reloads from its static level and its aging timer clears.
- R10: Whenever at least one request is pending at an edge, exactly one grant is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_q0 | input | 1 | Request from DMA queue 0 |
| req_q1 | input | 1 | Request from DMA queue 1 |
| req_cpu | input | 1 | Request from the CPU |
| lvl_q0 | input | LW (3) | Static level for queue 0 (0 = most urgent) |
| lvl_q1 | input | LW (3) | Static level for queue 1 |
| lvl_cpu | input | LW (3) | Static level for the CPU |
| age_interval | input | AW (8) | Waiting cycles per aging step; 0 disables aging |
| gnt_q0 | output | 1 | Registered grant to queue 0 |
| gnt_q1 | output | 1 | Registered grant to queue 1 |
| gnt_cpu | output | 1 | Registered grant to the CPU |

## Verification
The bench counts the exact edge at which an aging DMA request first overtakes a more urgent CPU. A design that ages on the wrong edge, or off by one against the interval, grants one or more cycles early or late. A reload test drops a partly aged request just before it would win, then raises it again. A design that keeps the aged level hands it a grant it should not get. The saturation test holds a queue at the winning position long enough that a level which wrapped past 0 would lose the next contest to an equally urgent CPU. Further tests check that tie order is fixed, that the CPU never gains urgency, and that interval 0 leaves only the static levels in effect.

// File: rtl/aging_arbiter.sv
module aging_arbiter #(
  parameter int LW = 3,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_q0,
  input  logic          req_q1,
  input  logic          req_cpu,
  input  logic [LW-1:0] lvl_q0,
  input  logic [LW-1:0] lvl_q1,
  input  logic [LW-1:0] lvl_cpu,
  input  logic [AW-1:0] age_interval,
  output logic          gnt_q0,
  output logic          gnt_q1,
  output logic          gnt_cpu
);

  localparam int NDMA = 2;

  logic [LW-1:0] eff  [NDMA];
  logic [AW-1:0] tmr  [NDMA];
  logic [LW-1:0] slvl [NDMA];
  logic [NDMA-1:0] dreq, dgnt;

  logic [LW-1:0] eff_q0, eff_q1;
  logic aging_on;
  logic [AW-1:0] last_tick;

  assign dreq     = {req_q1, req_q0};
  assign dgnt     = {gnt_q1, gnt_q0};
  assign slvl[0]  = lvl_q0;
  assign slvl[1]  = lvl_q1;
  assign eff_q0   = eff[0];
  assign eff_q1   = eff[1];
  assign aging_on = (age_interval != '0);
  assign last_tick = age_interval - AW'(1);

  for (genvar i = 0; i < NDMA; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        eff[i] <= '0;
        tmr[i] <= '0;
      end else if (!dreq[i] || dgnt[i] || !aging_on) begin
        eff[i] <= slvl[i];
        tmr[i] <= '0;
      end else if (tmr[i] == last_tick) begin
        tmr[i] <= '0;
        if (eff[i] != '0) eff[i] <= eff[i] - LW'(1);
      end else begin
        tmr[i] <= tmr[i] + AW'(1);
      end
    end
  end

  logic win_q0, win_q1, win_cpu;

  assign win_q0  = req_q0 && (!req_q1 || eff_q0 <= eff_q1)
                          && (!req_cpu || eff_q0 <= lvl_cpu);
  assign win_q1  = req_q1 && (!req_q0 || eff_q1 < eff_q0)
                          && (!req_cpu || eff_q1 <= lvl_cpu);
  assign win_cpu = req_cpu && !win_q0 && !win_q1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q0  <= 1'b0;
      gnt_q1  <= 1'b0;
      gnt_cpu <= 1'b0;
    end else begin
      gnt_q0  <= win_q0;
      gnt_q1  <= win_q1;
      gnt_cpu <= win_cpu;
    end
  end

endmodule

module aging_arbiter_chk #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_q0,
  input logic          req_q1,
  input logic          req_cpu,
  input logic          gnt_q0,
  input logic          gnt_q1,
  input logic          gnt_cpu,
  input logic          aging_on,
  input logic [LW-1:0] eff_q0,
  input logic [LW-1:0] eff_q1
);

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_q0, gnt_q1, gnt_cpu}));

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((!gnt_q0 || $past(req_q0)) && (!gnt_q1 || $past(req_q1))
                      && (!gnt_cpu || $past(req_cpu))));

  assert_work_conserving_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && (req_q0 || req_q1 || req_cpu)) |-> (gnt_q0 || gnt_q1 || gnt_cpu));

  assert_tie_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && req_q0 && req_q1 && eff_q0 <= eff_q1) |-> !gnt_q1);

  assert_aging_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && aging_on && req_q0 && !gnt_q0) |-> (eff_q0 <= $past(eff_q0)));

  assert_aging_monotone_q1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && aging_on && req_q1 && !gnt_q1) |-> (eff_q1 <= $past(eff_q1)));

endmodule

bind aging_arbiter aging_arbiter_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_q0(req_q0), .req_q1(req_q1), .req_cpu(req_cpu),
  .gnt_q0(gnt_q0), .gnt_q1(gnt_q1), .gnt_cpu(gnt_cpu),
  .aging_on(aging_on), .eff_q0(eff_q0), .eff_q1(eff_q1)
);

// File: tb/aging_arbiter_test.sv
module aging_arbiter_test;
  localparam int PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_q0 = 0, req_q1 = 0, req_cpu = 0;
  logic [2:0] lvl_q0 = 0, lvl_q1 = 0, lvl_cpu = 7;
  logic [7:0] age_interval = 0;
  logic gnt_q0, gnt_q1, gnt_cpu;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  aging_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .req_q0(req_q0), .req_q1(req_q1), .req_cpu(req_cpu),
    .lvl_q0(lvl_q0), .lvl_q1(lvl_q1), .lvl_cpu(lvl_cpu),
    .age_interval(age_interval),
    .gnt_q0(gnt_q0), .gnt_q1(gnt_q1), .gnt_cpu(gnt_cpu)
  );

  // {req cpu,q1,q0} {lvl q0} {lvl q1} {lvl cpu} {expected gnt cpu,q1,q0}
  localparam logic [14:0] VEC [NV] = '{
    {3'b001, 3'd7, 3'd0, 3'd0, 3'b001},
    {3'b010, 3'd0, 3'd7, 3'd0, 3'b010},
    {3'b100, 3'd0, 3'd0, 3'd7, 3'b100},
    {3'b111, 3'd3, 3'd3, 3'd3, 3'b001},
    {3'b110, 3'd0, 3'd4, 3'd4, 3'b010},
    {3'b111, 3'd5, 3'd2, 3'd6, 3'b010},
    {3'b111, 3'd5, 3'd6, 3'd1, 3'b100},
    {3'b101, 3'd0, 3'd3, 3'd0, 3'b001},
    {3'b111, 3'd7, 3'd7, 3'd7, 3'b001},
    {3'b011, 3'd6, 3'd5, 3'd0, 3'b010},
    {3'b000, 3'd1, 3'd2, 3'd3, 3'b000},
    {3'b101, 3'd2, 3'd0, 3'd1, 3'b100}
  };

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input string what, input logic [2:0] exp);
    logic [2:0] act;
    act = {gnt_cpu, gnt_q1, gnt_q0};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle;
    req_q0 = 0; req_q1 = 0; req_cpu = 0;
    tick(2);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    req_q0 = 1; req_cpu = 1;
    tick(3);
    check("R1", "grants in reset", 3'b000);
    req_q0 = 0; req_cpu = 0;
    rst_n = 1;
    tick(1);
    check("R2", "idle after reset", 3'b000);

    // R3 R4 R2: static arbitration table, aging off
    for (int i = 0; i < NV; i++) begin
      lvl_q0 = VEC[i][11:9]; lvl_q1 = VEC[i][8:6]; lvl_cpu = VEC[i][5:3];
      idle();
      {req_cpu, req_q1, req_q0} = VEC[i][14:12];
      tick(1);
      check("R3", $sformatf("vector %0d", i), VEC[i][2:0]);
    end

    // R5: interval 2, queue 0 level 5 vs CPU level 2
    idle();
    lvl_q0 = 5; lvl_cpu = 2; age_interval = 2;
    idle();
    req_q0 = 1; req_cpu = 1;
    tick(6);
    check("R5", "cpu still wins after edge 6", 3'b100);
    tick(1);
    check("R5", "aged queue 0 wins at edge 7", 3'b001);
    // R9: grant reloads the level -> cpu next
    tick(1);
    check("R9", "edge 8 uses aged level", 3'b001);
    tick(1);
    check("R9", "reloaded after grant", 3'b100);

    // R9: dropping the request reloads the level
    idle();
    lvl_q0 = 6; lvl_cpu = 2; age_interval = 1;
    idle();
    req_q0 = 1; req_cpu = 1;
    tick(4);
    req_q0 = 0;
    tick(1);
    check("R9", "cpu while queue 0 dropped", 3'b100);
    req_q0 = 1;
    tick(1);
    check("R9", "reload on drop keeps cpu ahead", 3'b100);

    // R6: interval 0, no aging over many cycles
    idle();
    lvl_q0 = 7; lvl_cpu = 0; age_interval = 0;
    idle();
    req_q0 = 1; req_cpu = 1;
    tick(40);
    check("R6", "no aging with interval 0", 3'b100);

    // R7: CPU never ages, even with interval 1
    idle();
    lvl_q0 = 1; lvl_q1 = 2; lvl_cpu = 3; age_interval = 1;
    idle();
    req_q0 = 1; req_cpu = 1;
    tick(30);
    check("R7", "cpu level unchanged by waiting", 3'b001);

    // R8: queue 1 aged to 0 while queue 0 wins; no wrap
    idle();
    lvl_q0 = 0; lvl_q1 = 1; lvl_cpu = 0; age_interval = 1;
    idle();
    req_q0 = 1; req_q1 = 1; req_cpu = 1;
    tick(5);
    check("R8", "queue 0 holds the bus", 3'b001);
    req_q0 = 0;
    tick(1);
    check("R8", "saturated queue 1 beats cpu tie", 3'b010);

    // R10: single request after mixed traffic always served
    idle();
    req_cpu = 1;
    tick(1);
    check("R10", "lone cpu served", 3'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule